// File: doc/BRIEF.md
# Store Alignment and Byte-Lane Unit

This unit sits behind instruction decode and turns each store into write cycles on a 32-bit, byte-enabled memory port. Each request carries a base register value, a signed 16-bit displacement, a store kind, the index of the floating-point source register, and up to two 32-bit source words. The unit adds the displacement to the base to form the effective address. It checks that the address is aligned for the access size and then places the source bytes on the lanes of the write port. Memory is big-endian, so the lowest byte address maps to the most significant lane.

Integer byte, half-word and word stores, and single-precision float stores, each take one write cycle. A double-precision store takes its data from an even/odd floating-point register pair. The unit issues it as two back-to-back word writes. While the second write is pending, `busy` is high and new requests are dropped. A misaligned access, a double store from an odd register, or an undefined kind code raises a one-cycle fault and writes nothing. A small byte-enabled memory model inside the unit receives the writes. It has a combinational read port so that the stored contents can be inspected.

Top module: `store_lane_unit`

## Requirements
- R1: The effective address is the base plus the sign-extended 16-bit offset. `wr_addr` carries it with bits 1:0 cleared, one cycle after the request is accepted.
- R2: A byte store replicates source bits 7:0 on all four lanes. It enables only lane bit `3 - ea[1:0]` of `wr_be`, so offset 0 gives 4'b1000 and offset 3 gives 4'b0001.
- R3: A half-word store (kind 1) replicates source bits 15:0 on both halves. `wr_be` is 4'b1100 at ea[1]=0 and 4'b0011 at ea[1]=1.
- R4: Word (kind 2) and single-float (kind 3) stores write the source word unchanged, with `wr_be` = 4'b1111.
- R5: A half-word store with ea[0]=1, or a word or single store with ea[1:0]≠0, pulses `align_fault` for one cycle. In that cycle `wr_en` is 0 and `wr_be` is 0, and memory is left unchanged. Kind codes 0 (byte) never fault.
- R6: A double store (kind 4) writes `src_lo` (the even register) to ea on the first cycle and `src_hi` (the odd register) to ea+4 on the next cycle. `busy` is 1 during the first write and 0 during the second.
- R7: A double store faults as in R5 when ea[2:0]≠0 or when `src_reg` is odd. Kind codes 5 to 7 also fault.
- R8: A request presented while `busy` is 1 is ignored. It produces no write and no fault.
- R9: After reset, `wr_en`, `wr_be`, `busy` and `align_fault` are 0 and every memory word reads 0.
- R10: The memory model updates only the bytes whose enable is set. Lane 3 (bits 31:24) holds the byte at word offset 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Store request present this cycle |
| req_kind | input | 3 | 0 byte, 1 half, 2 word, 3 single, 4 double |
| base_addr | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| src_reg | input | 5 | Floating-point source register index (even for double) |
| src_lo | input | 32 | Source data, or even register of a pair |
| src_hi | input | 32 | Odd register of a pair |
| wr_en | output | 1 | Write cycle valid |
| wr_addr | output | 32 | Word-aligned write byte address |
| wr_data | output | 32 | Lane-steered write data |
| wr_be | output | 4 | Byte enables, bit 3 = most significant lane |
| align_fault | output | 1 | One-cycle alignment fault pulse |
| busy | output | 1 | Second double-store write pending |
| rd_addr | input | 32 | Inspection read byte address |
| rd_data | output | 32 | Memory word at rd_addr |

## Verification
Byte stores are tried at offsets 1 and 3 of one word. The read-back of the merged word shows both the lane order and that untouched bytes survive. A half-word at the upper offset, a word reached through a negative displacement, and a single float each check the size-dependent enable patterns and the sign extension. The fault cases set different low address bits for half, word and double, use an odd pair register, and use an undefined kind code. Together they show that each size applies its own alignment rule. A double store with a competing request held during its busy cycle shows the pair ordering, the ea+4 step, and that requests are dropped while `busy` is high.

// File: rtl/store_pkg.sv
package store_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned LANES  = DATA_W / 8;
    localparam int unsigned LANE_AW = $clog2(LANES);

    typedef enum logic [2:0] {
        SK_BYTE   = 3'd0,
        SK_HALF   = 3'd1,
        SK_WORD   = 3'd2,
        SK_SINGLE = 3'd3,
        SK_DOUBLE = 3'd4
    } store_kind_e;

    typedef struct packed {
        logic              wr_en;
        logic              busy;
        logic              fault;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] hi_data;
    } seq_state_t;

endpackage

// File: rtl/store_addr_gen.sv
module store_addr_gen
    import store_pkg::*;
#(
    parameter int unsigned OFF_W     = 16,
    parameter int unsigned REG_IDX_W = 5
) (
    input  logic [ADDR_W-1:0]    base,
    input  logic [OFF_W-1:0]     offset,
    input  logic [2:0]           kind,
    input  logic [REG_IDX_W-1:0] reg_idx,
    output logic [ADDR_W-1:0]    ea,
    output logic                 reject
);

    localparam int unsigned EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_ext;

    assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
    assign ea      = base + off_ext;

    always_comb begin
        case (kind)
            SK_BYTE:   reject = 1'b0;
            SK_HALF:   reject = ea[0];
            SK_WORD,
            SK_SINGLE: reject = |ea[1:0];
            SK_DOUBLE: reject = (|ea[2:0]) | reg_idx[0];
            default:   reject = 1'b1;
        endcase
    end

endmodule

// File: rtl/store_lane_steer.sv
module store_lane_steer
    import store_pkg::*;
(
    input  logic [2:0]         kind,
    input  logic [LANE_AW-1:0] low_addr,
    input  logic [DATA_W-1:0]  src,
    output logic [DATA_W-1:0]  data,
    output logic [LANES-1:0]   be
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int unsigned BE_POS = LANES - 1 - g;
        localparam int unsigned HALF_SEL = g % 2;

        always_comb begin
            case (kind)
                SK_BYTE: begin
                    data[g*8 +: 8] = src[7:0];
                    be[g]          = (low_addr == LANE_AW'(BE_POS));
                end
                SK_HALF: begin
                    data[g*8 +: 8] = src[HALF_SEL*8 +: 8];
                    be[g]          = (low_addr[LANE_AW-1:1] == BE_POS[LANE_AW-1:1]);
                end
                default: begin
                    data[g*8 +: 8] = src[g*8 +: 8];
                    be[g]          = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/store_mem_model.sv
module store_mem_model
    import store_pkg::*;
#(
    parameter int unsigned MEM_WORDS = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned IDX_W = $clog2(MEM_WORDS);

    logic [DATA_W-1:0] mem_q [MEM_WORDS];
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;

    assign wr_idx  = wr_addr[LANE_AW +: IDX_W];
    assign rd_idx  = rd_addr[LANE_AW +: IDX_W];
    assign rd_data = mem_q[rd_idx];

    for (genvar g = 0; g < LANES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < MEM_WORDS; w++) begin
                    mem_q[w][g*8 +: 8] <= '0;
                end
            end else if (wr_en && wr_be[g]) begin
                mem_q[wr_idx][g*8 +: 8] <= wr_data[g*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/store_lane_unit.sv
module store_lane_unit
    import store_pkg::*;
#(
    parameter int unsigned OFF_W     = 16,
    parameter int unsigned REG_IDX_W = 5,
    parameter int unsigned MEM_WORDS = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [2:0]           req_kind,
    input  logic [ADDR_W-1:0]    base_addr,
    input  logic [OFF_W-1:0]     offset,
    input  logic [REG_IDX_W-1:0] src_reg,
    input  logic [DATA_W-1:0]    src_lo,
    input  logic [DATA_W-1:0]    src_hi,
    output logic                 wr_en,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [DATA_W-1:0]    wr_data,
    output logic [LANES-1:0]     wr_be,
    output logic                 align_fault,
    output logic                 busy,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data
);

    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(LANES);

    logic [ADDR_W-1:0] ea;
    logic              reject;
    logic [DATA_W-1:0] lane_data;
    logic [LANES-1:0]  lane_be;
    seq_state_t        st_d;
    seq_state_t        st_q;

    store_addr_gen #(
        .OFF_W     (OFF_W),
        .REG_IDX_W (REG_IDX_W)
    ) u_addr (
        .base    (base_addr),
        .offset  (offset),
        .kind    (req_kind),
        .reg_idx (src_reg),
        .ea      (ea),
        .reject  (reject)
    );

    store_lane_steer u_steer (
        .kind     (req_kind),
        .low_addr (ea[LANE_AW-1:0]),
        .src      (src_lo),
        .data     (lane_data),
        .be       (lane_be)
    );

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        st_d.fault = 1'b0;
        st_d.be    = '0;
        if (st_q.busy) begin
            st_d.wr_en = 1'b1;
            st_d.busy  = 1'b0;
            st_d.addr  = st_q.addr + WORD_STEP;
            st_d.data  = st_q.hi_data;
            st_d.be    = '1;
        end else if (req_valid) begin
            if (reject) begin
                st_d.fault = 1'b1;
            end else begin
                st_d.wr_en   = 1'b1;
                st_d.addr    = {ea[ADDR_W-1:LANE_AW], {LANE_AW{1'b0}}};
                st_d.data    = lane_data;
                st_d.be      = lane_be;
                st_d.busy    = (req_kind == SK_DOUBLE);
                st_d.hi_data = src_hi;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en       = st_q.wr_en;
    assign wr_addr     = st_q.addr;
    assign wr_data     = st_q.data;
    assign wr_be       = st_q.be;
    assign align_fault = st_q.fault;
    assign busy        = st_q.busy;

    store_mem_model #(
        .MEM_WORDS (MEM_WORDS)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_q.wr_en),
        .wr_addr (st_q.addr),
        .wr_data (st_q.data),
        .wr_be   (st_q.be),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/store_lane_chk.sv
module store_lane_chk
    import store_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [LANES-1:0]  wr_be,
    input logic              align_fault,
    input logic              busy
);

    // R5
    fault_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> (!wr_en && wr_be == '0));

    // R6
    busy_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> wr_en);

    // R6
    second_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (wr_en && !busy && wr_be == '1 && wr_addr == $past(wr_addr) + ADDR_W'(LANES)));

    // R8
    busy_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !align_fault);

    // R1
    word_aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr[LANE_AW-1:0] == '0));

    // R2
    lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($countones(wr_be) == 1 || $countones(wr_be) == 2 || wr_be == '1));

    // R9
    idle_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (wr_be == '0));

endmodule

bind store_lane_unit store_lane_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_be       (wr_be),
    .align_fault (align_fault),
    .busy        (busy)
);

// File: tb/tb_store_lane_unit.sv
`timescale 1ns/1ps
module tb_store_lane_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  req_kind;
    logic [31:0] base_addr;
    logic [15:0] offset;
    logic [4:0]  src_reg;
    logic [31:0] src_lo;
    logic [31:0] src_hi;
    logic        wr_en;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;
    logic        align_fault;
    logic        busy;
    logic [31:0] rd_addr;
    logic [31:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    store_lane_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .base_addr(base_addr), .offset(offset), .src_reg(src_reg),
        .src_lo(src_lo), .src_hi(src_hi), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .align_fault(align_fault), .busy(busy),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    typedef struct packed {
        logic [2:0]  kind;
        logic [31:0] base;
        logic [15:0] off;
        logic [4:0]  rg;
        logic [31:0] lo;
        logic        fault;
        logic [3:0]  be;
        logic [31:0] addr;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 32'h100, 16'h0001, 5'd0, 32'h000000AB, 1'b0, 4'b0100, 32'h100, 32'hABABABAB}, // R2
        '{3'd0, 32'h103, 16'h0000, 5'd0, 32'h000000CD, 1'b0, 4'b0001, 32'h100, 32'hCDCDCDCD}, // R2
        '{3'd1, 32'h110, 16'h0002, 5'd0, 32'hAAAA1234, 1'b0, 4'b0011, 32'h110, 32'h12341234}, // R3
        '{3'd1, 32'h120, 16'hFFFF, 5'd0, 32'h0000BEEF, 1'b1, 4'b0000, 32'h0,   32'h0},        // R5
        '{3'd2, 32'h200, 16'hFFFC, 5'd0, 32'hDEADBEEF, 1'b0, 4'b1111, 32'h1FC, 32'hDEADBEEF}, // R1 R4
        '{3'd3, 32'h030, 16'h0010, 5'd7, 32'h3F800000, 1'b0, 4'b1111, 32'h040, 32'h3F800000}, // R4
        '{3'd2, 32'h302, 16'h0000, 5'd0, 32'h12345678, 1'b1, 4'b0000, 32'h0,   32'h0},        // R5
        '{3'd4, 32'h404, 16'h0000, 5'd4, 32'h99999999, 1'b1, 4'b0000, 32'h0,   32'h0},        // R7
        '{3'd4, 32'h500, 16'h0000, 5'd3, 32'h88888888, 1'b1, 4'b0000, 32'h0,   32'h0},        // R7
        '{3'd6, 32'h600, 16'h0000, 5'd0, 32'h77777777, 1'b1, 4'b0000, 32'h0,   32'h0}         // R7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] k, input logic [31:0] b, input logic [15:0] o,
                         input logic [4:0] r, input logic [31:0] lo, input logic [31:0] hi);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = k;
        base_addr = b;
        offset    = o;
        src_reg   = r;
        src_lo    = lo;
        src_hi    = hi;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic peek(input logic [31:0] a, input logic [31:0] exp, input string req);
        rd_addr = a;
        #0.5;
        check(req, rd_data, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; base_addr = '0; offset = '0;
        src_reg = '0; src_lo = '0; src_hi = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        check("R9 wr_en", {31'b0, wr_en}, 32'h0);
        check("R9 wr_be", {28'b0, wr_be}, 32'h0);
        check("R9 busy", {31'b0, busy}, 32'h0);
        check("R9 fault", {31'b0, align_fault}, 32'h0);
        peek(32'h100, 32'h0, "R9 mem clear");

        // table walk: R1 R2 R3 R4 R5 R7
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].kind, VECS[i].base, VECS[i].off, VECS[i].rg, VECS[i].lo, 32'h0);
            check($sformatf("vec%0d fault", i), {31'b0, align_fault}, {31'b0, VECS[i].fault});
            check($sformatf("vec%0d wr_en", i), {31'b0, wr_en}, {31'b0, ~VECS[i].fault});
            check($sformatf("vec%0d be", i), {28'b0, wr_be}, {28'b0, VECS[i].be});
            if (!VECS[i].fault) begin
                check($sformatf("vec%0d R1 addr", i), wr_addr, VECS[i].addr);
                check($sformatf("vec%0d data", i), wr_data, VECS[i].data);
            end
        end
        @(negedge clk);

        // R10 merged bytes, R5 untouched words
        peek(32'h100, 32'h00AB00CD, "R10 byte merge");
        peek(32'h110, 32'h00001234, "R10 half low");
        peek(32'h1FC, 32'hDEADBEEF, "R4 word mem");
        peek(32'h040, 32'h3F800000, "R4 single mem");
        peek(32'h11C, 32'h0, "R5 mem unchanged");
        peek(32'h300, 32'h0, "R5 mem unchanged word");

        // R6 double store, R8 competing request during busy
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'd4; base_addr = 32'h80; offset = 16'h0008;
        src_reg = 5'd6; src_lo = 32'h11112222; src_hi = 32'h33334444;
        @(negedge clk);
        req_kind = 3'd2; base_addr = 32'h2C0; offset = 16'h0; src_lo = 32'h55555555;
        check("R6 first wr_en", {31'b0, wr_en}, 32'h1);
        check("R6 first addr", wr_addr, 32'h88);
        check("R6 first data", wr_data, 32'h11112222);
        check("R6 busy high", {31'b0, busy}, 32'h1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R6 second wr_en", {31'b0, wr_en}, 32'h1);
        check("R6 second addr", wr_addr, 32'h8C);
        check("R6 second data", wr_data, 32'h33334444);
        check("R6 busy low", {31'b0, busy}, 32'h0);
        check("R8 no fault", {31'b0, align_fault}, 32'h0);
        @(negedge clk);
        check("R8 no extra write", {31'b0, wr_en}, 32'h0);
        peek(32'h88, 32'h11112222, "R6 even mem");
        peek(32'h8C, 32'h33334444, "R6 odd mem");
        peek(32'h2C0, 32'h0, "R8 ignored mem");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule